// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block receives low-speed USB packets from the raw D+ and D- lines. Its system clock runs at eleven clocks per bus bit. A J-to-non-J transition on an idle bus arms a hunt for the sync field. During the hunt, every J-to-K edge re-centres an eleven-step phase counter, and the receiver locks once two K bit times in a row have been sampled at their centres. From then on, each bus transition nudges the sampling point by one clock toward the bit centre. This lets a packet be received when the sender's bit clock is about one percent off.

Once locked, the centre samples are NRZI-decoded. Stuffed bits are removed and are not written into a byte. The data bits are packed least significant bit first into bytes, and each completed byte is presented with its buffer index. An SE0 at a sample point closes the packet and reports its length. A byte beyond the buffer size aborts the packet with a sticky overflow flag. A hunt that sees no K edge in time ends with a timeout pulse, which is also how a keep-alive SE0 shows up.

Top module: `ls_rx_core`

## Requirements
- R1: Line states are {D+,D-}: J=01 (idle), K=10, SE0=00. After reset, and for as long as the bus stays J, every output is 0.
- R2: A hunt starts when the sampled line leaves J. The packet data begins after two consecutive bit-centre samples read K. A sync that never produces two K samples delivers no byte and no packet.
- R3: If a hunt sees no J-to-K edge within SYNC_WAIT_BITS*BIT_CLKS clocks (33 by default), `tmo_evt` pulses for one cycle and no packet is reported. A keep-alive (two bit times of SE0, then J) produces exactly this pulse.
- R4: NRZI decoding: a bit whose D- level equals the previous bit's level decodes as 1, and a change decodes as 0. The final K of the sync is the first reference level.
- R5: After six consecutive decoded 1s, the next bit is dropped and is not packed. The final sync bit counts as the first of these 1s.
- R6: Data bits are packed LSB first. Each completed byte gives a one-cycle `byte_vld` with `byte_data`, and `byte_addr` counts 0,1,2,... within the packet.
- R7: SE0 at a bit-centre sample ends the packet. `pkt_done` pulses with `pkt_len` set to the number of complete bytes. Trailing bits of an incomplete byte are discarded, and a packet with no data gives length 0.
- R8: When byte number BUF_BYTES+1 completes, it is not written. `err_ovf` is set, no `pkt_done` follows, and the rest of the packet is ignored until SE0.
- R9: `err_ovf` holds its value through timeouts and idle time. It clears only when a later sync completes.
- R10: The sampling point follows the bus. An 8-byte packet is received correctly when one bit in every ten is one clock longer, and also when one bit in every ten is one clock shorter.
- R11: `byte_vld`, `pkt_done` and `tmo_evt` are never high in the same cycle, and two `byte_vld` pulses are never adjacent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, BIT_CLKS periods per bus bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_dp | input | 1 | D+ line, already synchronous to clk |
| usb_dm | input | 1 | D- line, already synchronous to clk |
| byte_vld | output | 1 | One-cycle strobe for a received byte |
| byte_data | output | 8 | Received byte |
| byte_addr | output | $clog2(BUF_BYTES) | Buffer index of the byte |
| pkt_done | output | 1 | One-cycle end-of-packet strobe |
| pkt_len | output | $clog2(BUF_BYTES+1) | Byte count of the finished packet |
| err_ovf | output | 1 | Sticky buffer-overflow flag |
| tmo_evt | output | 1 | One-cycle sync-timeout / keep-alive strobe |

## Verification
The byte counter's limit test and the completion of a byte fall on the same bit-centre sample. On that sample, the write is suppressed and the overflow flag is raised. This is provoked by sending ten bytes into an eight-byte buffer. The check is that exactly eight bytes arrive, `err_ovf` rises with no strobe in that cycle, no `pkt_done` follows, and the flag survives a keep-alive until the next sync. Edge tracking and the centre sample can also coincide under drift. The drifted 8-byte packets show that the nudge never skips or repeats a sample.

// File: rtl/ls_rx_pkg.sv
package ls_rx_pkg;
  typedef logic [1:0] line_t;  // {D+, D-}
  localparam line_t LN_J   = 2'b01;
  localparam line_t LN_K   = 2'b10;
  localparam line_t LN_SE0 = 2'b00;
  typedef enum logic [1:0] {ST_IDLE, ST_HUNT, ST_RECV, ST_DRAIN} rx_state_e;
endpackage

// File: rtl/ls_rx_phase.sv
// Bit-phase counter: realigns on a hunt edge, nudges by one clock on data edges.
module ls_rx_phase #(
  parameter int BIT_CLKS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic realign,
  input  logic track_en,
  input  logic edge_seen,
  output logic samp
);
  localparam int PW  = $clog2(BIT_CLKS);
  localparam int CTR = BIT_CLKS / 2;

  logic [PW-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = (ph_q == PW'(BIT_CLKS - 1)) ? '0 : ph_q + PW'(1);
    if (realign) begin
      ph_d = PW'(1);
    end else if (track_en && edge_seen) begin
      if (ph_q != '0 && ph_q < PW'(CTR)) begin
        ph_d = ph_q;                                   // edge late: hold one clock
      end else if (ph_q > PW'(CTR + 1)) begin           // edge early: skip one clock
        ph_d = (ph_q >= PW'(BIT_CLKS - 2)) ? ph_q - PW'(BIT_CLKS - 2) : ph_q + PW'(2);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign samp = (ph_q == PW'(CTR));
endmodule

// File: rtl/ls_rx_bitdec.sv
// NRZI decode, stuffed-bit removal and LSB-first packing.
module ls_rx_bitdec #(
  parameter int BYTE_W    = 8,
  parameter int STUFF_RUN = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              shift_en,
  input  logic              level,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val
);
  localparam int OW = $clog2(STUFF_RUN + 1);
  localparam int BW = $clog2(BYTE_W);

  logic              prev_q, prev_d;
  logic [OW-1:0]     ones_q, ones_d;
  logic [BW-1:0]     cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              bit_v, stuffed;

  always_comb begin
    bit_v     = (level == prev_q);
    stuffed   = (ones_q == OW'(STUFF_RUN));
    byte_val  = {bit_v, sh_q[BYTE_W-1:1]};
    byte_done = shift_en && !stuffed && (cnt_q == BW'(BYTE_W - 1));
    prev_d = prev_q;
    ones_d = ones_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    if (start) begin
      prev_d = 1'b0;       // sync ends on K, D- low
      ones_d = OW'(1);     // final sync bit decodes as 1
      cnt_d  = '0;
      sh_d   = '0;
    end else if (shift_en) begin
      prev_d = level;
      if (stuffed) begin
        ones_d = '0;
      end else begin
        ones_d = bit_v ? ones_q + OW'(1) : '0;
        sh_d   = byte_val;
        cnt_d  = cnt_q + BW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      ones_q <= '0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else begin
      prev_q <= prev_d;
      ones_q <= ones_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
    end
  end
endmodule

// File: rtl/ls_rx_core.sv
module ls_rx_core #(
  parameter int BIT_CLKS       = 11,
  parameter int BUF_BYTES      = 8,
  parameter int SYNC_WAIT_BITS = 3,
  localparam int AW = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1,
  localparam int LW = $clog2(BUF_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          usb_dp,
  input  logic          usb_dm,
  output logic          byte_vld,
  output logic [7:0]    byte_data,
  output logic [AW-1:0] byte_addr,
  output logic          pkt_done,
  output logic [LW-1:0] pkt_len,
  output logic          err_ovf,
  output logic          tmo_evt
);
  import ls_rx_pkg::*;

  localparam int WAIT_CLKS = SYNC_WAIT_BITS * BIT_CLKS;
  localparam int WW        = $clog2(WAIT_CLKS + 1);

  line_t     line_q, line_qq;
  rx_state_e st_q, st_d;
  logic [WW-1:0] wait_q, wait_d;
  logic      kseen_q, kseen_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic      bv_q, bv_d, pd_q, pd_d, te_q, te_d, ovf_q, ovf_d;
  logic [7:0] data_q, data_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] len_q, len_d;

  logic edge_seen, arm, jk_edge, samp, realign, track_en;
  logic dec_start, shift_en, byte_done;
  logic [7:0] byte_val;

  assign edge_seen = (line_q != line_qq);
  assign arm       = (line_qq == LN_J) && (line_q != LN_J);
  assign jk_edge   = (line_qq == LN_J) && (line_q == LN_K);

  ls_rx_phase #(.BIT_CLKS(BIT_CLKS)) u_phase (
    .clk(clk), .rst_n(rst_n), .realign(realign), .track_en(track_en),
    .edge_seen(edge_seen), .samp(samp)
  );

  ls_rx_bitdec #(.BYTE_W(8), .STUFF_RUN(6)) u_dec (
    .clk(clk), .rst_n(rst_n), .start(dec_start), .shift_en(shift_en),
    .level(line_q[0]), .byte_done(byte_done), .byte_val(byte_val)
  );

  always_comb begin
    st_d = st_q;  wait_d = wait_q;  kseen_d = kseen_q;  cnt_d = cnt_q;
    realign = 1'b0;  track_en = 1'b0;  dec_start = 1'b0;  shift_en = 1'b0;
    bv_d = 1'b0;  pd_d = 1'b0;  te_d = 1'b0;  ovf_d = ovf_q;
    data_d = data_q;  addr_d = addr_q;  len_d = len_q;
    unique case (st_q)
      ST_IDLE: begin
        if (arm) begin
          st_d = ST_HUNT;  realign = 1'b1;  wait_d = '0;  kseen_d = 1'b0;
        end
      end
      ST_HUNT: begin
        wait_d = wait_q + WW'(1);
        if (jk_edge) begin
          realign = 1'b1;  wait_d = '0;
        end
        if (samp) begin
          if (line_q == LN_K) begin
            kseen_d = 1'b1;
            if (kseen_q) begin
              st_d = ST_RECV;  dec_start = 1'b1;  cnt_d = '0;  ovf_d = 1'b0;
            end
          end else begin
            kseen_d = 1'b0;
          end
        end else if (!jk_edge && wait_q == WW'(WAIT_CLKS - 1)) begin
          te_d = 1'b1;  st_d = ST_IDLE;
        end
      end
      ST_RECV: begin
        track_en = 1'b1;
        if (samp) begin
          if (line_q == LN_SE0) begin
            pd_d = 1'b1;  len_d = cnt_q;  st_d = ST_IDLE;
          end else begin
            shift_en = 1'b1;
            if (byte_done) begin
              if (cnt_q == LW'(BUF_BYTES)) begin
                ovf_d = 1'b1;  st_d = ST_DRAIN;
              end else begin
                bv_d = 1'b1;  data_d = byte_val;  addr_d = cnt_q[AW-1:0];
                cnt_d = cnt_q + LW'(1);
              end
            end
          end
        end
      end
      default: begin
        if (line_q == LN_SE0) st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= LN_J;  line_qq <= LN_J;  st_q <= ST_IDLE;
      wait_q <= '0;  kseen_q <= 1'b0;  cnt_q <= '0;
      bv_q <= 1'b0;  pd_q <= 1'b0;  te_q <= 1'b0;  ovf_q <= 1'b0;
      data_q <= '0;  addr_q <= '0;  len_q <= '0;
    end else begin
      line_q <= {usb_dp, usb_dm};  line_qq <= line_q;  st_q <= st_d;
      wait_q <= wait_d;  kseen_q <= kseen_d;  cnt_q <= cnt_d;
      bv_q <= bv_d;  pd_q <= pd_d;  te_q <= te_d;  ovf_q <= ovf_d;
      if (bv_d) begin
        data_q <= data_d;  addr_q <= addr_d;
      end
      if (pd_d) len_q <= len_d;
    end
  end

  assign byte_vld  = bv_q;
  assign byte_data = data_q;
  assign byte_addr = addr_q;
  assign pkt_done  = pd_q;
  assign pkt_len   = len_q;
  assign err_ovf   = ovf_q;
  assign tmo_evt   = te_q;
endmodule

// File: rtl/ls_rx_chk.sv
module ls_rx_chk #(
  parameter int BUF_BYTES = 8,
  localparam int AW = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1,
  localparam int LW = $clog2(BUF_BYTES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          byte_vld,
  input logic [AW-1:0] byte_addr,
  input logic          pkt_done,
  input logic [LW-1:0] pkt_len,
  input logic          err_ovf,
  input logic          tmo_evt
);
  p_events_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({byte_vld, pkt_done, tmo_evt}));
  p_byte_spacing_r11: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);
  p_addr_in_buffer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> (int'(byte_addr) < BUF_BYTES));
  p_len_in_buffer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> (int'(pkt_len) <= BUF_BYTES));
  p_no_write_on_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_ovf) |-> (!byte_vld && !pkt_done));
  p_ovf_holds_on_tmo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_evt && $past(err_ovf)) |-> err_ovf);
endmodule

bind ls_rx_core ls_rx_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_addr(byte_addr),
  .pkt_done(pkt_done), .pkt_len(pkt_len), .err_ovf(err_ovf), .tmo_evt(tmo_evt)
);

// File: tb/tb_ls_rx_core.sv
module tb_ls_rx_core;
  localparam int BITC = 11;
  localparam int BUFB = 8;
  localparam int AW   = $clog2(BUFB);
  localparam int LW   = $clog2(BUFB + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic usb_dp, usb_dm;
  logic byte_vld, pkt_done, err_ovf, tmo_evt;
  logic [7:0] byte_data;
  logic [AW-1:0] byte_addr;
  logic [LW-1:0] pkt_len;

  always #5 clk = ~clk;

  ls_rx_core #(.BIT_CLKS(BITC), .BUF_BYTES(BUFB), .SYNC_WAIT_BITS(3)) dut (
    .clk(clk), .rst_n(rst_n), .usb_dp(usb_dp), .usb_dm(usb_dm),
    .byte_vld(byte_vld), .byte_data(byte_data), .byte_addr(byte_addr),
    .pkt_done(pkt_done), .pkt_len(pkt_len), .err_ovf(err_ovf), .tmo_evt(tmo_evt)
  );

  typedef struct { int kind; int data; int aux; } ev_t;  // kind 0 byte, 1 done, 2 timeout
  ev_t exp_q[$];
  bit  tx_bits[$];
  logic [7:0] pb[$];
  int nchk = 0, nbad = 0, drift = 0, bit_idx = 0;
  bit mon_on = 1'b0, ended = 1'b0;

  localparam logic [1:0] LJ = 2'b01, LK = 2'b10, LS = 2'b00;

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  endtask

  // per-clock comparison of the event stream against the model's queue
  always @(negedge clk) begin
    if (mon_on) begin
      if (byte_vld) begin
        if (exp_q.size() == 0 || exp_q[0].kind != 0) chk(0, "R6 unexpected byte", byte_data, -1);
        else begin
          chk(byte_data == exp_q[0].data[7:0], "R4/R5 byte value", byte_data, exp_q[0].data);
          chk(int'(byte_addr) == exp_q[0].aux, "R6 byte address", byte_addr, exp_q[0].aux);
          void'(exp_q.pop_front());
        end
      end
      if (pkt_done) begin
        if (exp_q.size() == 0 || exp_q[0].kind != 1) chk(0, "R7/R8 unexpected done", pkt_len, -1);
        else begin
          chk(int'(pkt_len) == exp_q[0].aux, "R7 packet length", pkt_len, exp_q[0].aux);
          void'(exp_q.pop_front());
        end
      end
      if (tmo_evt) begin
        if (exp_q.size() == 0 || exp_q[0].kind != 2) chk(0, "R2/R3 unexpected timeout", 1, 0);
        else void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_up();
  end

  task automatic put(input logic [1:0] ln);
    int len;
    len = BITC;
    if (drift != 0 && (bit_idx % 10) == 9) len += drift;
    bit_idx++;
    {usb_dp, usb_dm} = ln;
    repeat (len) @(negedge clk);
  endtask

  function automatic logic [1:0] lv(input logic dm);
    return dm ? LJ : LK;
  endfunction

  task automatic send_packet();
    logic lvl;
    int ones;
    repeat (4) put(LJ);
    put(LK); put(LJ); put(LK); put(LJ); put(LK); put(LJ); put(LK); put(LK);
    lvl = 1'b0; ones = 1;
    foreach (tx_bits[i]) begin
      if (ones == 6) begin lvl = ~lvl; put(lv(lvl)); ones = 0; end
      if (tx_bits[i]) ones++;
      else begin lvl = ~lvl; ones = 0; end
      put(lv(lvl));
    end
    put(LS); put(LS);
    repeat (4) put(LJ);
    tx_bits.delete();
  endtask

  // build bits and expected events from pb; extra trailing bits in tail
  task automatic load(input int tail_bits, input int tail_val);
    int n;
    n = pb.size();
    foreach (pb[i]) begin
      for (int b = 0; b < 8; b++) tx_bits.push_back(pb[i][b]);
      if (i < BUFB) exp_q.push_back('{0, int'(pb[i]), i});
    end
    for (int b = 0; b < tail_bits; b++) tx_bits.push_back(tail_val[b]);
    if (n <= BUFB) exp_q.push_back('{1, 0, n});
    pb.delete();
  endtask

  task automatic drained(input string tag);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    rst_n = 1'b0; usb_dp = 1'b0; usb_dm = 1'b1;
    repeat (3) @(negedge clk);
    chk({byte_vld, pkt_done, err_ovf, tmo_evt} == 4'b0, "R1 reset outputs",
        {byte_vld, pkt_done, err_ovf, tmo_evt}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;
    repeat (20) put(LJ);
    chk({byte_vld, pkt_done, err_ovf, tmo_evt} == 4'b0, "R1 idle outputs",
        {byte_vld, pkt_done, err_ovf, tmo_evt}, 0);
    drained("R1 idle events");

    // R4 R6 plain bytes
    pb = '{8'hC3, 8'h5A, 8'h00};
    load(0, 0); send_packet(); drained("R4 R6 plain packet");

    // R5 long runs of ones
    pb = '{8'hFF, 8'hFF, 8'h7E, 8'h3F};
    load(0, 0); send_packet(); drained("R5 stuffed packet");

    // R7 trailing partial byte, then empty packet
    pb = '{8'hA5};
    load(3, 5); send_packet(); drained("R7 partial byte");
    load(0, 0); send_packet(); drained("R7 empty packet");

    // R2 broken sync: K then idle, expect only a timeout
    repeat (4) put(LJ);
    put(LK);
    exp_q.push_back('{2, 0, 0});
    repeat (6) put(LJ);
    drained("R2 incomplete sync");

    // R10 slow sender, full buffer
    drift = 1;
    for (int i = 0; i < BUFB; i++) pb.push_back(8'(i * 37 + 11));
    load(0, 0); send_packet(); drained("R10 slow drift");
    // R10 fast sender
    drift = -1;
    pb = '{8'hFF, 8'h01, 8'hFE, 8'h80, 8'hF0, 8'h0F, 8'hFF, 8'h55};
    load(0, 0); send_packet(); drained("R10 fast drift");
    drift = 0;
    chk(err_ovf == 1'b0, "R8 no overflow at limit", err_ovf, 0);

    // R8 overflow: ten bytes into eight
    for (int i = 0; i < 10; i++) pb.push_back(8'(8'hC1 ^ (i * 29)));
    load(0, 0); send_packet(); drained("R8 overflow events");
    chk(err_ovf == 1'b1, "R8 overflow flag", err_ovf, 1);

    // R3 keep-alive, R9 flag survives it
    repeat (4) put(LJ);
    exp_q.push_back('{2, 0, 0});
    put(LS); put(LS);
    repeat (5) put(LJ);
    drained("R3 keep-alive timeout");
    chk(err_ovf == 1'b1, "R9 flag held over timeout", err_ovf, 1);

    // R9 cleared by next sync
    pb = '{8'h3C};
    load(0, 0); send_packet(); drained("R9 packet after overflow");
    chk(err_ovf == 1'b0, "R9 flag cleared by sync", err_ovf, 0);

    finish_up();
  end
endmodule